// File: doc/BRIEF.md
# One-Shot Up-Counting Timer with Compare

The block is an up-counter that advances by one on each cycle in which a single-cycle count-tick enable is high. A small control register holds three bits: a run enable, a one-shot mode select and an overflow flag. A width-select input picks 8-bit or 16-bit operation. In free-running mode the counter rolls from full scale back to zero and raises the overflow flag. In one-shot mode it raises the flag when it arrives at full scale and stays there.

Software restarts a finished one-shot run by writing the control register with the flag bit at zero. The counter then reloads zero and counts again from the next tick. Two compare registers each drive an interrupt line. An interrupt line gives a one-cycle pulse when the counter takes on the programmed value.

Control and compare writes are sampled on the rising clock edge at which their strobe is high. They take effect in that same edge's update. Outputs are registered, so every effect is visible in the cycle after that edge.

Top module: `oneshot_timer`

## Requirements
- R1: The control byte has the run enable at bit 0, one-shot mode at bit 5 and the overflow flag at bit 6. A control write is applied at the edge where `ctl_wr` is high. Writing 1 to bit 6 leaves the flag unchanged. Reset clears the count, all three control bits and both interrupt lines.
- R2: Writing enable=1 while stopped loads zero into the count. The tick in that same cycle is ignored, and counting starts with the next tick.
- R3: While enabled and not held, each cycle with `tick` high adds one to the count, and a cycle without `tick` leaves the count unchanged.
- R4: In one-shot mode, the step that reaches full scale (0xFF in 8-bit mode, 0xFFFF in 16-bit mode) sets the overflow flag. The count then holds at full scale whatever the ticks do.
- R5: A control write that clears the enable bit sets the count to zero at that edge. The count stays at zero while enable is low.
- R6: Writing enable=1 when enable is already 1 does not disturb the running count.
- R7: A control write with bit 6 at zero while the one-shot count holds at full scale reloads zero. Counting resumes on the next tick.
- R8: In free-running mode, a tick at full scale wraps the count to zero, sets the overflow flag and counting continues.
- R9: Each compare line pulses high for exactly one cycle, in the cycle in which the count shows a value equal to its compare register. This applies only when that value was loaded by a start, a restart or a tick step. It is not repeated while the count is held.
- R10: With `wide_mode` low, the upper count byte stays zero, full scale is 0xFF and only the low compare byte is matched.
- R11: A write that clears the overflow flag takes priority over a full-scale event in the same cycle, so the flag reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-clock enable, one cycle per count |
| wide_mode | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 0 enable, bit 5 one-shot, bit 6 flag) |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_sel | input | 1 | Selects which compare register is written |
| cmp_wdata | input | 16 | Compare write data |
| count | output | 16 | Current counter value |
| run_en | output | 1 | Enable bit |
| oneshot_mode | output | 1 | One-shot mode bit |
| ovf_flag | output | 1 | Overflow flag |
| cmp_irq | output | 2 | Compare interrupt pulses, one per compare register |

## Verification
Two events can fall on the same edge: a software write that clears the overflow flag, and the one-shot count stepping onto full scale, which sets that flag. The bench provokes this directly by issuing the clearing write together with the tick that moves the count from 0xFE to 0xFF. It then expects the count at 0xFF with the flag low, and expects a second clearing write to restart the count from zero. The random phase issues control writes alongside ticks throughout, so the same collision, and a flag-clear landing on a wrap in free-running mode, recur. A bench model built from the requirements judges each cycle.

// File: rtl/oneshot_timer_pkg.sv
// Shared constants and types for the one-shot timer.
// Assumes an 8-bit control byte; bit positions are fixed by software convention.
package oneshot_timer_pkg;
    localparam int CTL_W        = 8;
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_MODE_BIT = 5;
    localparam int CTL_OVF_BIT  = 6;

    // Decoded control events for one clock edge.
    typedef struct packed {
        logic start;     // enable written 1 while it was 0
        logic stop;      // enable written 0 while it was 1
        logic flag_clr;  // control write with the flag bit at 0
    } ctl_evt_t;
endpackage

// File: rtl/ost_ctrl.sv
// Control register of the timer: enable, one-shot mode and overflow flag.
// Decodes writes into start/stop/flag-clear events for the counter.
// Assumes writes are single-cycle strobes; the flag is set only by hardware.
module ost_ctrl
    import oneshot_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             ovf_set,
    output logic             run_en,
    output logic             oneshot,
    output logic             ovf_flag,
    output ctl_evt_t         evt
);

    // Decode this cycle's write into events.
    always_comb begin
        evt.start    = ctl_wr &&  ctl_wdata[CTL_EN_BIT] && !run_en;
        evt.stop     = ctl_wr && !ctl_wdata[CTL_EN_BIT] &&  run_en;
        evt.flag_clr = ctl_wr && !ctl_wdata[CTL_OVF_BIT];
    end

    // Hold the enable and mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en  <= 1'b0;
            oneshot <= 1'b0;
        end else if (ctl_wr) begin
            run_en  <= ctl_wdata[CTL_EN_BIT];
            oneshot <= ctl_wdata[CTL_MODE_BIT];
        end
    end

    // Overflow flag: a software clear beats a hardware set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (evt.flag_clr) begin
            ovf_flag <= 1'b0;
        end else if (ovf_set) begin
            ovf_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/ost_counter.sv
// Up-counter with start, stop, one-shot hold/restart and free-running wrap.
// Exposes the next value and an update strobe so compare units can
// register their pulse in step with the count. Assumes tick is one cycle wide.
module ost_counter
    import oneshot_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wide_mode,
    input  logic             run_en,
    input  logic             oneshot,
    input  ctl_evt_t         evt,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_nxt,
    output logic [CNT_W-1:0] full_mask,
    output logic             upd,
    output logic             ovf_set
);
    localparam int          PAD_W     = CNT_W - NARROW_W;
    localparam logic [CNT_W-1:0] NARROW_FULL = {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [CNT_W-1:0] WIDE_FULL   = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] inc;
    logic             at_full;
    logic             held;

    // Full-scale value and masked current count for the chosen width.
    always_comb begin
        full_mask = wide_mode ? WIDE_FULL : NARROW_FULL;
        cur       = count_q & full_mask;
        inc       = cur + 1'b1;
        at_full   = (cur == full_mask);
        held      = oneshot && at_full;
    end

    // Next-count selection in priority order: stop, start, restart, step.
    always_comb begin
        count_nxt = cur;
        upd       = 1'b0;
        ovf_set   = 1'b0;
        if (evt.stop) begin
            count_nxt = '0;
        end else if (evt.start) begin
            count_nxt = '0;
            upd       = 1'b1;
        end else if (run_en && held && evt.flag_clr) begin
            count_nxt = '0;
            upd       = 1'b1;
        end else if (run_en && tick && !held) begin
            upd = 1'b1;
            if (at_full) begin
                count_nxt = '0;
                ovf_set   = 1'b1;
            end else begin
                count_nxt = inc;
                ovf_set   = oneshot && (inc == full_mask);
            end
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_nxt;
        end
    end

endmodule

// File: rtl/ost_compare.sv
// One compare register with its interrupt pulse.
// Pulses when a freshly loaded count equals the register under the width mask.
// Assumes upd marks every edge where the count takes a new value by counting.
module ost_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] mask,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic             upd,
    output logic             irq
);
    logic [CNT_W-1:0] cmp_q;
    logic             hit;

    // Masked equality against the next count.
    always_comb hit = (((count_nxt ^ cmp_q) & mask) == '0);

    // Compare value storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr) begin
            cmp_q <= wdata;
        end
    end

    // Interrupt pulse, aligned with the count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= upd && hit;
        end
    end

endmodule

// File: rtl/oneshot_timer.sv
// Top level: control register, counter and a bank of compare units.
// Assumes all write strobes are synchronous to clk and one cycle wide.
module oneshot_timer
    import oneshot_timer_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NARROW_W  = 8,
    parameter int NUM_CMP   = 2,
    parameter int CMP_SEL_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 wide_mode,
    input  logic                 ctl_wr,
    input  logic [CTL_W-1:0]     ctl_wdata,
    input  logic                 cmp_wr,
    input  logic [CMP_SEL_W-1:0] cmp_sel,
    input  logic [CNT_W-1:0]     cmp_wdata,
    output logic [CNT_W-1:0]     count,
    output logic                 run_en,
    output logic                 oneshot_mode,
    output logic                 ovf_flag,
    output logic [NUM_CMP-1:0]   cmp_irq
);
    ctl_evt_t         evt;
    logic             ovf_set;
    logic             upd;
    logic [CNT_W-1:0] count_nxt;
    logic [CNT_W-1:0] full_mask;

    ost_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ovf_set   (ovf_set),
        .run_en    (run_en),
        .oneshot   (oneshot_mode),
        .ovf_flag  (ovf_flag),
        .evt       (evt)
    );

    ost_counter #(
        .CNT_W    (CNT_W),
        .NARROW_W (NARROW_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wide_mode (wide_mode),
        .run_en    (run_en),
        .oneshot   (oneshot_mode),
        .evt       (evt),
        .count_q   (count),
        .count_nxt (count_nxt),
        .full_mask (full_mask),
        .upd       (upd),
        .ovf_set   (ovf_set)
    );

    for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
        ost_compare #(
            .CNT_W (CNT_W)
        ) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (cmp_wr && (cmp_sel == CMP_SEL_W'(gi))),
            .wdata     (cmp_wdata),
            .mask      (full_mask),
            .count_nxt (count_nxt),
            .upd       (upd),
            .irq       (cmp_irq[gi])
        );
    end

endmodule

// File: rtl/oneshot_timer_checker.sv
// Protocol checker for oneshot_timer, attached by bind.
// Observes ports only; assumes the 16-bit default width.
module oneshot_timer_checker #(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wide_mode,
    input logic               ctl_wr,
    input logic [7:0]         ctl_wdata,
    input logic               cmp_wr,
    input logic [CNT_W-1:0]   count,
    input logic               run_en,
    input logic               oneshot_mode,
    input logic               ovf_flag,
    input logic [NUM_CMP-1:0] cmp_irq
);
    localparam logic [CNT_W-1:0] WIDE_FULL = {CNT_W{1'b1}};

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_wdata[0] && !run_en |=> count == '0); // R2

    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !ctl_wdata[0] |=> count == '0); // R5

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> count == '0); // R5

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && oneshot_mode && wide_mode && count == WIDE_FULL && !ctl_wr
        |=> count == WIDE_FULL || !wide_mode); // R4

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode && $stable(wide_mode) |-> count[CNT_W-1:8] == '0); // R10

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !ctl_wdata[6] |=> !ovf_flag); // R11

    for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_irq
        AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_irq[gi] && !$past(cmp_wr) && $stable(wide_mode)
            |=> !cmp_irq[gi]); // R9
    end

endmodule

bind oneshot_timer oneshot_timer_checker #(
    .CNT_W   (CNT_W),
    .NUM_CMP (NUM_CMP)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide_mode    (wide_mode),
    .ctl_wr       (ctl_wr),
    .ctl_wdata    (ctl_wdata),
    .cmp_wr       (cmp_wr),
    .count        (count),
    .run_en       (run_en),
    .oneshot_mode (oneshot_mode),
    .ovf_flag     (ovf_flag),
    .cmp_irq      (cmp_irq)
);

// File: tb/oneshot_timer_test.sv
// Self-checking bench: directed corner cases plus seeded random stimulus,
// compared every cycle against a behavioural model of the requirements.
module oneshot_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wide_mode = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic        cmp_wr = 1'b0;
    logic [0:0]  cmp_sel = 1'b0;
    logic [15:0] cmp_wdata = 16'h0000;
    logic [15:0] count;
    logic        run_en;
    logic        oneshot_mode;
    logic        ovf_flag;
    logic [1:0]  cmp_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Model state.
    logic        m_en = 0, m_mode = 0, m_ovf = 0;
    logic [15:0] m_cnt = 0;
    logic [15:0] m_cmp [2] = '{16'h0, 16'h0};
    logic [1:0]  m_irq = 0;
    string       phase = "R3";

    always #5 clk = ~clk;

    oneshot_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wide_mode(wide_mode),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .cmp_wr(cmp_wr),
        .cmp_sel(cmp_sel), .cmp_wdata(cmp_wdata), .count(count),
        .run_en(run_en), .oneshot_mode(oneshot_mode), .ovf_flag(ovf_flag),
        .cmp_irq(cmp_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] full_of(input logic w);
        return w ? 16'hFFFF : 16'h00FF;
    endfunction

    // Advance the model by one edge from the inputs currently driven.
    task automatic model_step();
        logic [15:0] full, cur, nx;
        logic upd, set, clr, start, stop, held;
        full = full_of(wide_mode);
        cur  = m_cnt & full;
        nx = cur; upd = 0; set = 0;
        start = ctl_wr && ctl_wdata[0] && !m_en;
        stop  = ctl_wr && !ctl_wdata[0] && m_en;
        clr   = ctl_wr && !ctl_wdata[6];
        held  = m_mode && cur == full;
        if (stop) nx = 0;
        else if (start) begin nx = 0; upd = 1; end
        else if (m_en && held && clr) begin nx = 0; upd = 1; end
        else if (m_en && tick && !held) begin
            upd = 1;
            if (cur == full) begin nx = 0; set = 1; end
            else begin nx = cur + 16'd1; set = m_mode && nx == full; end
        end
        for (int i = 0; i < 2; i++) m_irq[i] = upd && (((nx ^ m_cmp[i]) & full) == 0);
        if (cmp_wr) m_cmp[cmp_sel] = cmp_wdata;
        m_cnt = nx;
        if (clr) m_ovf = 0; else if (set) m_ovf = 1;
        if (ctl_wr) begin m_en = ctl_wdata[0]; m_mode = ctl_wdata[5]; end
    endtask

    // One clock with the given inputs; compares all outputs to the model.
    task automatic cyc(input logic t, input logic wr, input logic [7:0] wd,
                       input logic cw, input logic cs, input logic [15:0] cd);
        tick = t; ctl_wr = wr; ctl_wdata = wd; cmp_wr = cw; cmp_sel = cs; cmp_wdata = cd;
        model_step();
        @(posedge clk);
        @(negedge clk);
        tick = 0; ctl_wr = 0; cmp_wr = 0;
        check(count == m_cnt && ovf_flag == m_ovf && run_en == m_en &&
              oneshot_mode == m_mode && cmp_irq == m_irq, phase,
              {count, 4'h0, cmp_irq, run_en, ovf_flag, 7'h0, oneshot_mode},
              {m_cnt, 4'h0, m_irq, m_en, m_ovf, 7'h0, m_mode});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 8'h00, 0, 0, 16'h0);
    endtask
    task automatic ctl(input logic [7:0] v);
        cyc(0, 1, v, 0, 0, 16'h0);
    endtask
    task automatic setcmp(input logic s, input logic [15:0] v);
        cyc(0, 0, 8'h00, 1, s, v);
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [7:0] wd;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(count == 0 && !ovf_flag && !run_en && !oneshot_mode && cmp_irq == 0, "R1",
              {count, cmp_irq, run_en, ovf_flag}, 0);

        wide_mode = 0;
        phase = "R10";
        setcmp(0, 16'h0005);
        setcmp(1, 16'h0107);
        phase = "R2";
        ctl(8'h21);
        check(run_en && oneshot_mode && count == 0, "R1", {count, run_en, oneshot_mode}, {16'h0, 2'b11});
        check(count == 16'h0, "R2", count, 0);
        phase = "R3";
        ticks(5);
        check(count == 16'd5, "R3", count, 5);
        check(cmp_irq[0] == 1'b1, "R9", cmp_irq, 1);
        cyc(0, 0, 8'h00, 0, 0, 16'h0);
        check(count == 16'd5, "R3", count, 5);
        check(cmp_irq[0] == 1'b0, "R9", cmp_irq, 0);
        phase = "R6";
        ctl(8'h21);
        check(count == 16'd5 && run_en, "R6", count, 5);
        phase = "R10";
        ticks(2);
        check(count == 16'd7 && cmp_irq[1] == 1'b1, "R10", {count, cmp_irq}, {16'd7, 2'b10});
        setcmp(0, 16'h00FF);
        phase = "R4";
        ticks(248);
        check(count == 16'h00FF && ovf_flag, "R4", {count, ovf_flag}, {16'h00FF, 1'b1});
        check(cmp_irq[0] == 1'b1, "R9", cmp_irq, 1);
        ticks(3);
        check(count == 16'h00FF && cmp_irq == 0, "R4", {count, cmp_irq}, {16'h00FF, 2'b00});
        check(count[15:8] == 8'h00, "R10", count, 16'h00FF);
        phase = "R7";
        ctl(8'h21);
        check(count == 0 && !ovf_flag, "R7", {count, ovf_flag}, 0);
        ticks(1);
        check(count == 16'd1, "R7", count, 1);
        phase = "R11";
        ticks(253);
        check(count == 16'h00FE, "R3", count, 16'h00FE);
        cyc(1, 1, 8'h21, 0, 0, 16'h0);
        check(count == 16'h00FF && !ovf_flag, "R11", {count, ovf_flag}, {16'h00FF, 1'b0});
        ctl(8'h21);
        check(count == 16'h0, "R7", count, 0);
        phase = "R5";
        ticks(3);
        ctl(8'h00);
        check(count == 0 && !run_en, "R5", {count, run_en}, 0);
        ticks(2);
        check(count == 0, "R5", count, 0);
        phase = "R8";
        ctl(8'h01);
        ticks(255);
        check(count == 16'h00FF && !ovf_flag, "R8", {count, ovf_flag}, {16'h00FF, 1'b0});
        ticks(1);
        check(count == 16'h0 && ovf_flag, "R8", {count, ovf_flag}, {16'h0, 1'b1});
        ticks(1);
        check(count == 16'd1 && ovf_flag, "R8", {count, ovf_flag}, {16'd1, 1'b1});
        phase = "R4";
        ctl(8'h00);
        wide_mode = 1;
        setcmp(1, 16'hFFFF);
        ctl(8'h21);
        ticks(65535);
        check(count == 16'hFFFF && ovf_flag && cmp_irq[1], "R4",
              {count, ovf_flag, cmp_irq}, {16'hFFFF, 1'b1, 2'b10});
        ticks(2);
        check(count == 16'hFFFF && cmp_irq == 0, "R9", {count, cmp_irq}, {16'hFFFF, 2'b00});

        // Random phase: mixed ticks, control writes and compare writes.
        phase = "R3";
        for (int n = 0; n < 40000; n++) begin
            int r;
            r = $urandom % 1000;
            if (r < 2) wide_mode = ~wide_mode;
            if (r < 30) begin
                wd = 8'h00;
                wd[0] = ($urandom % 4) != 0;
                wd[5] = $urandom % 2;
                wd[6] = ($urandom % 3) == 0;
                cyc(($urandom % 2) == 1, 1, wd, 0, 0, 16'h0);
            end else if (r < 45) begin
                cyc(($urandom % 2) == 1, 0, 8'h00, 1, $urandom % 2, 16'($urandom % 300));
            end else begin
                cyc(($urandom % 10) < 8, 0, 8'h00, 0, 0, 16'h0);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule